// File: doc/BRIEF.md
# Prioritized Interrupt Arbitration Unit

This block collects interrupt requests from three serial sources: one synchronous serial port and two asynchronous ports, A and B. Each source has its own programmable 3-bit request level. The block shows the CPU the highest level that is pending and enabled. It leaves the comparison against the CPU's interrupt mask to the CPU.

When the CPU runs an acknowledge cycle, the block compares the acknowledged level with its own pending level. On an exact match it places its programmed 4-bit arbitration number on the bid output. The strongest competing number from other modules arrives as an input, and the block wins only when its number is strictly higher. In the cycle after a win, it drives an 8-bit vector. The upper six bits of the vector come from a programmed base, and the lower two bits name the interrupting source.

Configuration is written through a small register write port. All configuration fields reset to zero. An arbitration number of zero keeps the block out of every acknowledge cycle.

Top module: `irq_arb_unit`

## Requirements
- R1: A source whose programmed level is 0 never contributes to `irq_level`, even while its request input is high.
- R2: `irq_level` equals the highest programmed level among sources whose request is high and whose level is non-zero, and is 0 when there are none.
- R3: When several pending sources share the top level, the synchronous port takes precedence over port A, and port A over port B, for the vector code.
- R4: Requests are level-sensitive: lowering a request input removes that source from `irq_level` in the same cycle.
- R5: `arb_bid` is non-zero only while `iack_valid` is high, the pending level is non-zero and `iack_level` equals `irq_level`. In that case it equals the programmed arbitration number.
- R6: The arbitration number resets to 0. While it is 0, `arb_bid` stays 0, `arb_win` stays low and no vector is produced.
- R7: `arb_win` is high only when `arb_bid` is non-zero and strictly greater than `arb_other`. An equal number loses.
- R8: One cycle after `arb_win`, `vec_valid` is high and `vec_out` is {base[5:0], code}. The code is 2'b00 for port A, 2'b01 for port B and 2'b10 for the synchronous port. In every other cycle `vec_valid` is low and `vec_out` is 0.
- R9: A write with `cfg_wr` high stores `cfg_wdata` at `cfg_addr`. Address 0 holds the synchronous level (bits 2:0), 1 holds the port A level, 2 holds the port B level, 3 holds the arbitration number (bits 3:0) and 4 holds the vector base (bits 5:0). Addresses 5 to 7 change nothing, and all fields reset to 0.
- R10: The vector uses the base and source held in the win cycle. A base write at the same clock edge affects only later vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration field select |
| cfg_wdata | input | 8 | Configuration write data |
| req_sync | input | 1 | Request from synchronous serial port |
| req_async_a | input | 1 | Request from asynchronous port A |
| req_async_b | input | 1 | Request from asynchronous port B |
| irq_level | output | 3 | Highest enabled pending level |
| iack_valid | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level acknowledged by the CPU |
| arb_other | input | 4 | Highest arbitration number of other modules |
| arb_bid | output | 4 | Own arbitration number while competing, else 0 |
| arb_win | output | 1 | Arbitration won this cycle |
| vec_valid | output | 1 | Vector output valid |
| vec_out | output | 8 | Interrupt vector, zero when not valid |

## Verification
An acknowledge can win in the same cycle that software rewrites the vector base. It can also win in the same cycle that a source drops its request. The bench raises a win and a base write at one clock edge. It expects the vector to carry the old base, and the next winning acknowledge to carry the new base. In a separate case the synchronous request is lowered before an acknowledge at a shared level, and the bench checks that the code falls through to port A and then to port B.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC   = 3;
  localparam int LVL_W  = 3;
  localparam int ARB_W  = 4;
  localparam int BASE_W = 6;
  localparam int CODE_W = 2;
  localparam int VEC_W  = BASE_W + CODE_W;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  // priority index order: 0 = synchronous, 1 = port A, 2 = port B
  typedef enum logic [CODE_W-1:0] {
    CODE_ASYNC_A = 2'b00,
    CODE_ASYNC_B = 2'b01,
    CODE_SYNC    = 2'b10,
    CODE_NONE    = 2'b11
  } src_code_e;

  localparam logic [ADDR_W-1:0] FLD_LVL_SYNC = 3'd0;
  localparam logic [ADDR_W-1:0] FLD_LVL_A    = 3'd1;
  localparam logic [ADDR_W-1:0] FLD_LVL_B    = 3'd2;
  localparam logic [ADDR_W-1:0] FLD_ARB      = 3'd3;
  localparam logic [ADDR_W-1:0] FLD_BASE     = 3'd4;

  function automatic src_code_e idx_to_code(input logic [1:0] idx);
    case (idx)
      2'd0:    return CODE_SYNC;
      2'd1:    return CODE_ASYNC_A;
      2'd2:    return CODE_ASYNC_B;
      default: return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_arb_cfg.sv
module irq_arb_cfg #(
  parameter int LVL_W  = 3,
  parameter int ARB_W  = 4,
  parameter int BASE_W = 6,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LVL_W-1:0]  lvl_sync,
  output logic [LVL_W-1:0]  lvl_a,
  output logic [LVL_W-1:0]  lvl_b,
  output logic [ARB_W-1:0]  arb_num,
  output logic [BASE_W-1:0] vec_base
);
  import irq_arb_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_sync <= '0;
      lvl_a    <= '0;
      lvl_b    <= '0;
      arb_num  <= '0;
      vec_base <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        FLD_LVL_SYNC: lvl_sync <= wr_data[LVL_W-1:0];
        FLD_LVL_A:    lvl_a    <= wr_data[LVL_W-1:0];
        FLD_LVL_B:    lvl_b    <= wr_data[LVL_W-1:0];
        FLD_ARB:      arb_num  <= wr_data[ARB_W-1:0];
        FLD_BASE:     vec_base <= wr_data[BASE_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_arb_prio.sv
module irq_arb_prio #(
  parameter int NSRC  = 3,
  parameter int LVL_W = 3,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]             req,
  input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
  output logic                        any,
  output logic [LVL_W-1:0]            top_lvl,
  output logic [IDX_W-1:0]            top_idx
);
  logic [NSRC-1:0] live;

  for (genvar g = 0; g < NSRC; g++) begin : g_live
    assign live[g] = req[g] && (lvl[g] != '0);
  end

  assign any = |live;

  // index 0 has precedence; strict compare keeps the earlier index on a tie
  always_comb begin
    top_lvl = '0;
    top_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (live[i] && (lvl[i] > top_lvl)) begin
        top_lvl = lvl[i];
        top_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_arb_ack.sv
module irq_arb_ack #(
  parameter int LVL_W  = 3,
  parameter int ARB_W  = 4,
  parameter int BASE_W = 6,
  parameter int CODE_W = 2,
  localparam int VEC_W = BASE_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack_valid,
  input  logic [LVL_W-1:0]  iack_level,
  input  logic [ARB_W-1:0]  arb_other,
  input  logic              pend_any,
  input  logic [LVL_W-1:0]  pend_lvl,
  input  logic [CODE_W-1:0] pend_code,
  input  logic [ARB_W-1:0]  arb_num,
  input  logic [BASE_W-1:0] vec_base,
  output logic [ARB_W-1:0]  arb_bid,
  output logic              arb_win,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_out
);
  logic match;

  assign match   = iack_valid && pend_any && (iack_level == pend_lvl);
  assign arb_bid = (match && (arb_num != '0)) ? arb_num : '0;
  assign arb_win = (arb_bid != '0) && (arb_bid > arb_other);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      vec_valid <= arb_win;
      vec_out   <= arb_win ? {vec_base, pend_code} : '0;
    end
  end
endmodule

// File: rtl/irq_arb_unit.sv
module irq_arb_unit #(
  parameter int LVL_W  = irq_arb_pkg::LVL_W,
  parameter int ARB_W  = irq_arb_pkg::ARB_W,
  parameter int BASE_W = irq_arb_pkg::BASE_W,
  parameter int ADDR_W = irq_arb_pkg::ADDR_W,
  parameter int DATA_W = irq_arb_pkg::DATA_W,
  localparam int CODE_W = irq_arb_pkg::CODE_W,
  localparam int VEC_W  = BASE_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_sync,
  input  logic              req_async_a,
  input  logic              req_async_b,
  output logic [LVL_W-1:0]  irq_level,
  input  logic              iack_valid,
  input  logic [LVL_W-1:0]  iack_level,
  input  logic [ARB_W-1:0]  arb_other,
  output logic [ARB_W-1:0]  arb_bid,
  output logic              arb_win,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_out
);
  import irq_arb_pkg::*;
  localparam int IDX_W = $clog2(NSRC);

  logic [LVL_W-1:0]             lvl_sync, lvl_a, lvl_b;
  logic [ARB_W-1:0]             arb_num;
  logic [BASE_W-1:0]            vec_base;
  logic [NSRC-1:0]              req_vec;
  logic [NSRC-1:0][LVL_W-1:0]   lvl_vec;
  logic                         pend_any;
  logic [LVL_W-1:0]             pend_lvl;
  logic [IDX_W-1:0]             pend_idx;
  logic [CODE_W-1:0]            pend_code;

  irq_arb_cfg #(
    .LVL_W(LVL_W), .ARB_W(ARB_W), .BASE_W(BASE_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .lvl_sync(lvl_sync), .lvl_a(lvl_a), .lvl_b(lvl_b),
    .arb_num(arb_num), .vec_base(vec_base)
  );

  // packed in precedence order
  assign req_vec = {req_async_b, req_async_a, req_sync};
  assign lvl_vec = {lvl_b, lvl_a, lvl_sync};

  irq_arb_prio #(.NSRC(NSRC), .LVL_W(LVL_W)) u_prio (
    .req(req_vec), .lvl(lvl_vec),
    .any(pend_any), .top_lvl(pend_lvl), .top_idx(pend_idx)
  );

  assign pend_code = idx_to_code(2'(pend_idx));
  assign irq_level = pend_lvl;

  irq_arb_ack #(
    .LVL_W(LVL_W), .ARB_W(ARB_W), .BASE_W(BASE_W), .CODE_W(CODE_W)
  ) u_ack (
    .clk(clk), .rst_n(rst_n),
    .iack_valid(iack_valid), .iack_level(iack_level), .arb_other(arb_other),
    .pend_any(pend_any), .pend_lvl(pend_lvl), .pend_code(pend_code),
    .arb_num(arb_num), .vec_base(vec_base),
    .arb_bid(arb_bid), .arb_win(arb_win),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );
endmodule

// File: rtl/irq_arb_unit_chk.sv
module irq_arb_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] irq_level,
  input logic       iack_valid,
  input logic [2:0] iack_level,
  input logic [3:0] arb_other,
  input logic [3:0] arb_bid,
  input logic       arb_win,
  input logic       vec_valid,
  input logic [7:0] vec_out
);
  // R5
  bid_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_bid != 4'd0) |-> (iack_valid && (irq_level != 3'd0) && (iack_level == irq_level)));

  // R7
  win_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_win |-> ((arb_bid != 4'd0) && (arb_bid > arb_other)));

  // R8
  vec_follows_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_win |=> vec_valid);

  // R8
  vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_win |=> (!vec_valid && (vec_out == 8'd0)));

  // R8
  vec_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_out[1:0] != 2'b11));
endmodule

bind irq_arb_unit irq_arb_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_level(irq_level),
  .iack_valid(iack_valid), .iack_level(iack_level), .arb_other(arb_other),
  .arb_bid(arb_bid), .arb_win(arb_win),
  .vec_valid(vec_valid), .vec_out(vec_out)
);

// File: tb/irq_arb_unit_test.sv
module irq_arb_unit_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       req_sync, req_async_a, req_async_b;
  logic [2:0] irq_level;
  logic       iack_valid;
  logic [2:0] iack_level;
  logic [3:0] arb_other;
  logic [3:0] arb_bid;
  logic       arb_win;
  logic       vec_valid;
  logic [7:0] vec_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arb_unit uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_sync(req_sync), .req_async_a(req_async_a), .req_async_b(req_async_b),
    .irq_level(irq_level),
    .iack_valid(iack_valid), .iack_level(iack_level), .arb_other(arb_other),
    .arb_bid(arb_bid), .arb_win(arb_win),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_req(input logic s, input logic a, input logic b);
    @(negedge clk);
    req_sync = s; req_async_a = a; req_async_b = b;
    #1;
  endtask

  // one-cycle acknowledge; returns bid, win and the vector seen a cycle later
  task automatic ack(input logic [2:0] lvl, input logic [3:0] other,
                     output int bid, output int win, output int vv, output int vec);
    @(negedge clk);
    iack_valid = 1'b1; iack_level = lvl; arb_other = other;
    #1;
    bid = arb_bid; win = arb_win;
    @(negedge clk);
    iack_valid = 1'b0;
    #1;
    vv = vec_valid; vec = vec_out;
  endtask

  task automatic t_reset();
    chk("R6 bid after reset", arb_bid, 0);
    chk("R8 vec_valid after reset", vec_valid, 0);
    chk("R8 vec_out after reset", vec_out, 0);
    set_req(1, 1, 1);
    chk("R9 levels reset to zero", irq_level, 0);
    chk("R1 zero level masks request", irq_level, 0);
    set_req(0, 0, 0);
  endtask

  task automatic t_levels();
    cfg_write(3'd0, 8'd2);
    cfg_write(3'd1, 8'd5);
    cfg_write(3'd2, 8'd3);
    set_req(1, 1, 1);
    chk("R2 highest level", irq_level, 5);
    set_req(1, 0, 1);
    chk("R4 drop A removes it", irq_level, 3);
    cfg_write(3'd2, 8'd0);
    #1;
    chk("R1 B disabled by level 0", irq_level, 2);
    set_req(0, 0, 0);
    chk("R2 nothing pending", irq_level, 0);
    cfg_write(3'd5, 8'hFF);
    cfg_write(3'd7, 8'hFF);
    set_req(1, 1, 1);
    chk("R9 reserved address no effect", irq_level, 5);
    set_req(0, 0, 0);
  endtask

  task automatic t_zero_arb();
    int bid, win, vv, vec;
    cfg_write(3'd0, 8'd4);
    cfg_write(3'd1, 8'd4);
    cfg_write(3'd2, 8'd4);
    cfg_write(3'd4, 8'h2A);
    set_req(1, 1, 1);
    ack(3'd4, 4'd0, bid, win, vv, vec);
    chk("R6 zero number no bid", bid, 0);
    chk("R6 zero number no win", win, 0);
    chk("R6 zero number no vector", vec, 0);
    chk("R6 zero number vec_valid low", vv, 0);
  endtask

  task automatic t_tie();
    int bid, win, vv, vec;
    cfg_write(3'd3, 8'd5);
    ack(3'd4, 4'd0, bid, win, vv, vec);
    chk("R5 bid equals own number", bid, 5);
    chk("R7 win over 0", win, 1);
    chk("R8 vec_valid after win", vv, 1);
    chk("R3 sync wins tie", vec, 8'hAA);
    @(negedge clk); #1;
    chk("R8 vector cleared next cycle", vec_out, 0);
    set_req(0, 1, 1);
    ack(3'd4, 4'd0, bid, win, vv, vec);
    chk("R3 A beats B", vec, 8'hA8);
    set_req(0, 0, 1);
    ack(3'd4, 4'd0, bid, win, vv, vec);
    chk("R3 B alone code 01", vec, 8'hA9);
    set_req(1, 1, 1);
  endtask

  task automatic t_mismatch();
    int bid, win, vv, vec;
    ack(3'd3, 4'd0, bid, win, vv, vec);
    chk("R5 level mismatch no bid", bid, 0);
    chk("R5 level mismatch no vector", vv, 0);
  endtask

  task automatic t_compare();
    int bid, win, vv, vec;
    ack(3'd4, 4'd5, bid, win, vv, vec);
    chk("R7 equal number loses", win, 0);
    chk("R7 loss gives no vector", vec, 0);
    ack(3'd4, 4'd6, bid, win, vv, vec);
    chk("R7 higher other wins", win, 0);
    chk("R5 bid still shown on loss", bid, 5);
    ack(3'd4, 4'd4, bid, win, vv, vec);
    chk("R7 lower other loses to us", win, 1);
  endtask

  task automatic t_overlap();
    int bid, win, vv, vec;
    @(negedge clk);
    iack_valid = 1'b1; iack_level = 3'd4; arb_other = 4'd0;
    cfg_wr = 1'b1; cfg_addr = 3'd4; cfg_wdata = 8'h15;
    #1;
    chk("R10 win with write", arb_win, 1);
    @(negedge clk);
    iack_valid = 1'b0; cfg_wr = 1'b0;
    #1;
    chk("R10 vector keeps old base", vec_out, 8'hAA);
    ack(3'd4, 4'd0, bid, win, vv, vec);
    chk("R10 next vector uses new base", vec, 8'h56);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_sync = 1'b0; req_async_a = 1'b0; req_async_b = 1'b0;
    iack_valid = 1'b0; iack_level = '0; arb_other = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_levels();
    t_zero_arb();
    t_tie();
    t_mismatch();
    t_compare();
    t_overlap();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule